// File: doc/BRIEF.md
# Strided Beat Address Generator

This block produces the source and destination addresses for every beat of a block transfer inside a DMA engine. At the start of a block it captures a starting address for each side, a beat count and a configuration: the beat width, a separate increment enable for each side, a 3-bit step field, and a selector that says which side the step applies to. Each accepted advance strobe moves both addresses forward and counts the remaining beats down by one. A side whose increment is disabled keeps a fixed address, as a peripheral data register needs.

The side named by the selector moves by the beat width shifted left by the step field, which gives strided access. The other side, if it increments, moves by the beat width. A flag marks the final beat. A resume load replaces the addresses and the remaining count with saved values, so a block that was interrupted continues from where it stopped. Addresses wrap at 2^32, and the block does not check alignment.

Top module: `stride_addr_gen`

## Requirements
- R1: A `start` pulse loads `src_addr` from `src_start`, `dst_addr` from `dst_start` and `remaining` from `beat_cnt` on the next edge. It also captures the configuration inputs. `active` is then high exactly when the loaded count is nonzero.
- R2: The beat width code maps 0 to 1 byte, 1 to 2 bytes, 2 to 4 bytes and 3 to 4 bytes.
- R3: On each accepted advance, a side that increments and is not the stepped side gains exactly the beat width.
- R4: A side whose increment enable is low keeps its address through every advance. `inc_en` bit 0 controls the source and bit 1 controls the destination.
- R5: The stepped side (`step_sel` 0 for source, 1 for destination) gains the beat width times 2^`step_size` when its increment is enabled. A step field of 0 gives a stride of one beat.
- R6: An advance is accepted only while `remaining` is nonzero, and each accepted advance lowers `remaining` by one. An advance while `remaining` is 0 leaves both addresses and the count unchanged.
- R7: `last_beat` is high exactly when `remaining` equals 1, and `active` is high exactly when `remaining` is nonzero.
- R8: A `resume` pulse loads `src_addr`, `dst_addr` and `remaining` from `rsm_src`, `rsm_dst` and `rsm_cnt`, and captures the configuration inputs.
- R9: When strobes coincide, `start` takes precedence over `resume`, and `resume` takes precedence over `advance`.
- R10: Address arithmetic wraps modulo 2^32. For example, 0xFFFFFFFC plus 4 gives 0x00000000.
- R11: While `rst` is high, both addresses and `remaining` are 0, and `active` and `last_beat` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new block |
| resume | input | 1 | Restore a saved block state |
| advance | input | 1 | Move to the next beat |
| src_start | input | 32 | Source address of the first beat |
| dst_start | input | 32 | Destination address of the first beat |
| beat_cnt | input | 16 | Beats in the block |
| beat_size | input | 2 | Beat width code |
| inc_en | input | 2 | Increment enables: bit 0 source, bit 1 destination |
| step_size | input | 3 | Stride exponent for the stepped side |
| step_sel | input | 1 | Stepped side: 0 source, 1 destination |
| rsm_src | input | 32 | Saved source address |
| rsm_dst | input | 32 | Saved destination address |
| rsm_cnt | input | 16 | Saved remaining count |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| remaining | output | 16 | Beats still to go |
| last_beat | output | 1 | Current beat is the final one |
| active | output | 1 | Beats remain |

## Verification
The assertions make no assumption about how the three strobes combine. Any mix may arrive in the same cycle, so each property about stepping is guarded by the absence of `start` and `resume` in that cycle. They also take no alignment for granted: a start address can be any 32-bit value, and wrap-around is part of the checked behaviour. The random stimulus uses every beat width code including 3, every step value, both selectors and all enable pairs. It draws beat counts small enough that blocks often run out, so advances into an empty count are common. It mixes in occasional coincident start, resume and advance pulses, and starting addresses near the top of the address space.

// File: rtl/stride_pkg.sv
package stride_pkg;

    parameter int ADDR_W = 32;
    parameter int CNT_W  = 16;
    parameter int STEP_W = 3;
    parameter int NSIDE  = 2;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        BSZ_BYTE = 2'd0,
        BSZ_HALF = 2'd1,
        BSZ_WORD = 2'd2,
        BSZ_RSVD = 2'd3
    } bsz_e;

    typedef struct packed {
        bsz_e              size;
        logic [NSIDE-1:0]  inc_en;
        logic [STEP_W-1:0] step;
        logic              step_sel;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{size: BSZ_BYTE, inc_en: '0, step: '0, step_sel: 1'b0};

    function automatic addr_t width_bytes(bsz_e s);
        addr_t b;
        case (s)
            BSZ_BYTE: b = addr_t'(1);
            BSZ_HALF: b = addr_t'(2);
            default:  b = addr_t'(4);
        endcase
        return b;
    endfunction

    function automatic addr_t side_incr(cfg_t c, int side);
        addr_t base;
        base = width_bytes(c.size);
        if (!c.inc_en[side]) begin
            return '0;
        end
        if (int'(c.step_sel) == side) begin
            return base << c.step;
        end
        return base;
    endfunction

endpackage

// File: rtl/stride_cfg_reg.sv
module stride_cfg_reg
    import stride_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (capture) begin
            cfg_q <= cfg_in;
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(cfg_q)); // R1

endmodule

// File: rtl/stride_side.sv
module stride_side #(
    parameter int ADDR_W = stride_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] incr,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step_en) begin
            addr <= addr + incr;
        end
    end

    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_en) |=> $stable(addr)); // R6

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> addr == $past(load_val)); // R8

endmodule

// File: rtl/stride_beat_ctr.sv
module stride_beat_ctr #(
    parameter int CNT_W = stride_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             adv_req,
    output logic             accept,
    output logic [CNT_W-1:0] remaining,
    output logic             last_beat,
    output logic             active
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        active    = (remaining != '0);
        last_beat = (remaining == ONE);
        accept    = adv_req && active && !load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (accept) begin
            remaining <= remaining - ONE;
        end
    end

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
        (adv_req && !load && remaining != '0) |=> remaining == $past(remaining) - ONE); // R6

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && remaining == '0) |=> remaining == '0); // R6

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (last_beat && adv_req && !load) |=> !active); // R7

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
    import stride_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              resume,
    input  logic              advance,
    input  logic [ADDR_W-1:0] src_start,
    input  logic [ADDR_W-1:0] dst_start,
    input  logic [CNT_W-1:0]  beat_cnt,
    input  logic [1:0]        beat_size,
    input  logic [NSIDE-1:0]  inc_en,
    input  logic [STEP_W-1:0] step_size,
    input  logic              step_sel,
    input  logic [ADDR_W-1:0] rsm_src,
    input  logic [ADDR_W-1:0] rsm_dst,
    input  logic [CNT_W-1:0]  rsm_cnt,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic              last_beat,
    output logic              active
);

    logic              capture;
    logic              accept;
    cfg_t              cfg_in;
    cfg_t              cfg_q;
    logic [CNT_W-1:0]  cnt_load;
    logic [ADDR_W-1:0] start_addr [NSIDE];
    logic [ADDR_W-1:0] rsm_addr   [NSIDE];
    logic [ADDR_W-1:0] side_addr  [NSIDE];

    always_comb begin
        capture         = start || resume;
        cfg_in.size     = bsz_e'(beat_size);
        cfg_in.inc_en   = inc_en;
        cfg_in.step     = step_size;
        cfg_in.step_sel = step_sel;
        cnt_load        = start ? beat_cnt : rsm_cnt;
        start_addr[SIDE_SRC] = src_start;
        start_addr[SIDE_DST] = dst_start;
        rsm_addr[SIDE_SRC]   = rsm_src;
        rsm_addr[SIDE_DST]   = rsm_dst;
    end

    stride_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q)
    );

    stride_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (capture),
        .load_val  (cnt_load),
        .adv_req   (advance),
        .accept    (accept),
        .remaining (remaining),
        .last_beat (last_beat),
        .active    (active)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic [ADDR_W-1:0] ld_val;
        logic [ADDR_W-1:0] incr;
        always_comb begin
            ld_val = start ? start_addr[s] : rsm_addr[s];
            incr   = side_incr(cfg_q, s);
        end
        stride_side #(.ADDR_W(ADDR_W)) u_side (
            .clk      (clk),
            .rst      (rst),
            .load     (capture),
            .load_val (ld_val),
            .step_en  (accept),
            .incr     (incr),
            .addr     (side_addr[s])
        );
    end

    assign src_addr = side_addr[SIDE_SRC];
    assign dst_addr = side_addr[SIDE_DST];

    // Independent stride reference: shift amount is min(code,2) plus the step
    logic [3:0] wsh;
    logic [3:0] sh_src;
    logic [3:0] sh_dst;
    always_comb begin
        wsh    = (cfg_q.size == BSZ_BYTE) ? 4'd0 : (cfg_q.size == BSZ_HALF) ? 4'd1 : 4'd2;
        sh_src = wsh + ((cfg_q.step_sel == 1'b0) ? {1'b0, cfg_q.step} : 4'd0);
        sh_dst = wsh + ((cfg_q.step_sel == 1'b1) ? {1'b0, cfg_q.step} : 4'd0);
    end

    AST_SRC_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (advance && active && !capture && cfg_q.inc_en[SIDE_SRC])
        |=> src_addr == $past(src_addr) + (ADDR_W'(1) << $past(sh_src))); // R5

    AST_DST_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (advance && active && !capture && cfg_q.inc_en[SIDE_DST])
        |=> dst_addr == $past(dst_addr) + (ADDR_W'(1) << $past(sh_dst))); // R3

    AST_FIXED_SRC: assert property (@(posedge clk) disable iff (rst)
        (!capture && !cfg_q.inc_en[SIDE_SRC]) |=> $stable(src_addr)); // R4

    AST_FIXED_DST: assert property (@(posedge clk) disable iff (rst)
        (!capture && !cfg_q.inc_en[SIDE_DST]) |=> $stable(dst_addr)); // R4

    AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
        start |=> (src_addr == $past(src_start) && remaining == $past(beat_cnt))); // R9

    AST_LAST_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        last_beat |-> active); // R7

endmodule

// File: tb/tb_stride_addr_gen.sv
module tb_stride_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, resume, advance;
    logic [31:0] src_start, dst_start, rsm_src, rsm_dst;
    logic [15:0] beat_cnt, rsm_cnt;
    logic [1:0]  beat_size;
    logic [1:0]  inc_en;
    logic [2:0]  step_size;
    logic        step_sel;
    logic [31:0] src_addr, dst_addr;
    logic [15:0] remaining;
    logic        last_beat, active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model state
    logic [31:0] m_src, m_dst;
    logic [15:0] m_cnt;
    logic [1:0]  m_size;
    logic [1:0]  m_inc;
    logic [2:0]  m_step;
    logic        m_sel;

    always #5 clk = ~clk;

    stride_addr_gen dut (
        .clk(clk), .rst(rst), .start(start), .resume(resume), .advance(advance),
        .src_start(src_start), .dst_start(dst_start), .beat_cnt(beat_cnt),
        .beat_size(beat_size), .inc_en(inc_en), .step_size(step_size),
        .step_sel(step_sel), .rsm_src(rsm_src), .rsm_dst(rsm_dst), .rsm_cnt(rsm_cnt),
        .src_addr(src_addr), .dst_addr(dst_addr), .remaining(remaining),
        .last_beat(last_beat), .active(active)
    );

    function automatic logic [31:0] bytes_of(logic [1:0] code);
        if (code == 2'd0) return 32'd1;
        if (code == 2'd1) return 32'd2;
        return 32'd4;
    endfunction

    function automatic logic [31:0] exp_incr(int side);
        logic [31:0] b;
        b = bytes_of(m_size);
        if (!m_inc[side]) return 32'd0;
        if (int'(m_sel) == side) return b * (32'd1 << m_step);
        return b;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " src"}, src_addr, m_src);
        chk({tag, " dst"}, dst_addr, m_dst);
        chk({tag, " cnt"}, 32'(remaining), 32'(m_cnt));
        chk({tag, " last R7"}, 32'(last_beat), 32'(m_cnt == 16'd1));
        chk({tag, " active R7"}, 32'(active), 32'(m_cnt != 16'd0));
    endtask

    task automatic set_cfg(logic [1:0] sz, logic [1:0] ie, logic [2:0] st, logic sl);
        beat_size = sz; inc_en = ie; step_size = st; step_sel = sl;
    endtask

    // Drive at negedge, model the edge, compare at the next negedge
    task automatic cycle(logic st, logic rs, logic ad, string tag);
        start = st; resume = rs; advance = ad;
        if (st || rs) begin
            m_size = beat_size; m_inc = inc_en; m_step = step_size; m_sel = step_sel;
        end
        if (st) begin
            m_src = src_start; m_dst = dst_start; m_cnt = beat_cnt;
        end else if (rs) begin
            m_src = rsm_src; m_dst = rsm_dst; m_cnt = rsm_cnt;
        end else if (ad && m_cnt != 16'd0) begin
            m_src = m_src + exp_incr(0);
            m_dst = m_dst + exp_incr(1);
            m_cnt = m_cnt - 16'd1;
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; resume = 1'b0; advance = 1'b0;
        chk_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; start = 0; resume = 0; advance = 0;
        src_start = 0; dst_start = 0; rsm_src = 0; rsm_dst = 0;
        beat_cnt = 0; rsm_cnt = 0; set_cfg(0, 0, 0, 0);
        m_src = 0; m_dst = 0; m_cnt = 0; m_size = 0; m_inc = 0; m_step = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        chk_all("R11 reset");
        rst = 1'b0;

        // R1 start, R3 plain increment, R4 fixed side, R2 code 2 = 4 bytes
        src_start = 32'h1000; dst_start = 32'h2000; beat_cnt = 16'd3;
        set_cfg(2'd2, 2'b01, 3'd0, 1'b1);
        cycle(1, 0, 0, "R1 start");
        cycle(0, 0, 1, "R3 R4 beat1");
        chk("R3 src+4", src_addr, 32'h1004);
        chk("R4 dst fixed", dst_addr, 32'h2000);
        cycle(0, 0, 1, "R6 beat2");
        chk("R7 last at 1", 32'(last_beat), 32'd1);
        cycle(0, 0, 1, "R6 beat3");
        cycle(0, 0, 1, "R6 ignored when empty");
        chk("R6 src unchanged", src_addr, 32'h100C);

        // R5 stride on destination, R2 half-word
        src_start = 32'h100; dst_start = 32'h800; beat_cnt = 16'd4;
        set_cfg(2'd1, 2'b11, 3'd3, 1'b1);
        cycle(1, 0, 0, "R1 start2");
        cycle(0, 0, 1, "R5 stride");
        chk("R5 dst+16", dst_addr, 32'h810);
        chk("R2 src+2", src_addr, 32'h102);

        // R5 step 0 on source, R2 code 3 and code 0
        src_start = 32'h40; dst_start = 32'h80; beat_cnt = 16'd2;
        set_cfg(2'd3, 2'b11, 3'd0, 1'b0);
        cycle(1, 0, 0, "R1 start3");
        cycle(0, 0, 1, "R5 step0");
        chk("R2 code3 src+4", src_addr, 32'h44);
        set_cfg(2'd0, 2'b10, 3'd7, 1'b1);
        cycle(1, 0, 0, "R1 start4");
        cycle(0, 0, 1, "R2 byte stride");
        chk("R5 dst+128", dst_addr, 32'h100);

        // R10 wrap
        src_start = 32'hFFFF_FFFC; dst_start = 32'hFFFF_FFFF; beat_cnt = 16'd2;
        set_cfg(2'd2, 2'b11, 3'd0, 1'b1);
        cycle(1, 0, 0, "R1 start5");
        cycle(0, 0, 1, "R10 wrap");
        chk("R10 src wraps", src_addr, 32'h0);
        chk("R10 dst wraps", dst_addr, 32'h3);

        // R8 resume
        rsm_src = 32'hA000; rsm_dst = 32'hB000; rsm_cnt = 16'd5;
        set_cfg(2'd1, 2'b01, 3'd2, 1'b0);
        cycle(0, 1, 0, "R8 resume");
        chk("R8 count", 32'(remaining), 32'd5);
        cycle(0, 0, 1, "R8 continue");
        chk("R8 src+8", src_addr, 32'hA008);

        // R9 priorities
        src_start = 32'h7000; beat_cnt = 16'd9;
        cycle(1, 1, 1, "R9 start beats resume");
        chk("R9 start src", src_addr, 32'h7000);
        cycle(0, 1, 1, "R9 resume beats advance");
        chk("R9 resume src", src_addr, 32'hA000);

        // R1 zero count
        beat_cnt = 16'd0;
        cycle(1, 0, 0, "R1 zero count");
        chk("R1 inactive", 32'(active), 32'd0);
        cycle(0, 0, 1, "R6 zero ignored");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(99));
            src_start = ($urandom_range(3) == 0) ? (32'hFFFF_FF00 | 32'($urandom_range(255))) : $urandom;
            dst_start = $urandom;
            rsm_src = $urandom; rsm_dst = $urandom;
            beat_cnt = 16'($urandom_range(6));
            rsm_cnt = 16'($urandom_range(6));
            set_cfg(2'($urandom_range(3)), 2'($urandom_range(3)),
                    3'($urandom_range(7)), 1'($urandom_range(1)));
            if (r < 8)       cycle(1, 0, 0, "R1 rand");
            else if (r < 12) cycle(0, 1, 0, "R8 rand");
            else if (r < 15) cycle(1, 1, 1, "R9 rand");
            else if (r < 18) cycle(0, 1, 1, "R9 rand");
            else if (r < 80) cycle(0, 0, 1, "R3/R5/R6 rand");
            else             cycle(0, 0, 0, "R6 idle rand");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule